// File: doc/BRIEF.md
# Strobe-Driven Slave Port for Endpoint Buffers

The block lets logic outside the chip move data into and out of four endpoint buffers without any master on the chip side. The outside device drives the control strobes: an active-low select, read, write, output enable and a packet-commit strobe. It also drives a 2-bit buffer address and a 16-bit data bus. Every strobe is qualified by the select. The port reports the empty and full state of whichever buffer the address currently points at.

Each buffer has its own width bit. With the bit set, the buffer stores and returns full 16-bit words. With it clear, only the low byte is stored and returned, and only the low byte lane is driven. The port runs in one of two modes. In clocked mode, a strobe held high moves one unit on every interface clock edge. In edge mode, every rising edge of a strobe is resynchronised and moves exactly one unit, however long the strobe stays high. A commit strobe closes the packet being built in the addressed buffer and reports how many units it holds. A commit with no data reports a length of zero.

Top module: `slv_fifo_port`

## Requirements
- R1: While `cs_ni` is high, the read, write, output-enable and commit strobes have no effect. Nothing is pushed or popped, `data_oe_o` is 0 and no commit is reported.
- R2: `fifo_adr_i` (0 to 3) selects the one buffer that pushes, pops, commits, drives the flags and supplies read data. The other buffers keep their contents.
- R3: When bit `cfg_word_i[n]` is 1, buffer n moves 16-bit words and a driven read sets `data_oe_o` = 2'b11. When the bit is 0, a write stores `{8'h00, data_i[7:0]}`, a driven read sets `data_oe_o` = 2'b01, and `data_o[15:8]` is 0.
- R4: In clocked mode (`sync_mode_i` = 1), each clock edge at which a select-qualified write is high pushes `data_i`. Each edge at which a select-qualified read is high pops the head of the buffer.
- R5: In edge mode (`sync_mode_i` = 0), each rising edge of a select-qualified strobe causes exactly one action. The action takes place at the second clock edge after the first edge that samples the strobe high. `data_i` and `fifo_adr_i` are taken at that edge.
- R6: `data_oe_o` is non-zero only while `cs_ni` is low, `oe_i` is high and `wr_i` is low.
- R7: A commit sets `pkt_valid_o` high for the following cycle. In that cycle `pkt_ep_o` holds the address and `pkt_len_o` holds the number of pushes accepted into that buffer since its previous commit, counting a push in the same cycle. The count may be zero. The buffer's count then restarts at zero.
- R8: `empty_o` and `full_o` show the selected buffer's fill level after the most recent clock edge. A push into a full buffer is dropped and a pop from an empty buffer is ignored.
- R9: When `data_oe_o` is non-zero and the selected buffer holds data, `data_o` is its oldest entry, masked to the buffer's width. Otherwise `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | 1 = clocked strobes, 0 = edge strobes |
| cfg_word_i | input | 4 | Width bit per buffer, 1 = 16-bit |
| cs_ni | input | 1 | Port select, active low |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| oe_i | input | 1 | Output enable for the data bus |
| pktend_i | input | 1 | Packet-commit strobe |
| fifo_adr_i | input | 2 | Buffer address |
| data_i | input | 16 | Write data |
| data_o | output | 16 | Read data |
| data_oe_o | output | 2 | Per-lane drive enable |
| empty_o | output | 1 | Selected buffer empty |
| full_o | output | 1 | Selected buffer full |
| pkt_valid_o | output | 1 | Commit reported this cycle |
| pkt_ep_o | output | 2 | Buffer that was committed |
| pkt_len_o | output | 10 | Units in the committed packet |

## Verification
The main transfer path is tried with the following patterns:
- Back-to-back clocked writes and reads to a word buffer, then to the byte buffers. These show whether lanes are masked per buffer rather than globally.
- Interleaved traffic across all four addresses. This exposes any address decode that leaks into another buffer.
- Filling past capacity and draining past empty. These separate the overflow and underflow guards from the flag timing.
- Strobes with the select high, and output enable held during writes, in both modes. These distinguish gating faults from drive-suppression faults.
- Multi-cycle edge-mode pulses and commits with and without data. These show whether a long strobe moves one unit or many, and whether zero-length packets are counted.

// File: rtl/slv_fifo_pkg.sv
package slv_fifo_pkg;
  localparam int NUM_STB = 3;
  typedef enum logic [1:0] {
    STB_RD = 2'd0,
    STB_WR = 2'd1,
    STB_PE = 2'd2
  } stb_idx_e;
endpackage

// File: rtl/slv_strobe.sv
module slv_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_mode_i,
  input  logic lvl_i,
  output logic ev_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= lvl_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // clocked mode: level qualifies the edge; edge mode: one pulse per rise
  assign ev_o = sync_mode_i ? lvl_i : (s2_q & ~s3_q);
endmodule

// File: rtl/slv_ep_buf.sv
module slv_ep_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          acc_push_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == CW'(DEPTH));
  assign do_push    = push_i & ~full_o;
  assign do_pop     = pop_i & ~empty_o;
  assign acc_push_o = do_push;
  assign head_o     = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= din_i;
  end

  // DEPTH is a power of two, so pointers wrap naturally
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/slv_pkt_cnt.sv
module slv_pkt_cnt #(
  parameter int NUM_EP = 4,
  parameter int LEN_W  = 10,
  localparam int AW    = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EP-1:0] acc_push_i,
  input  logic              commit_i,
  input  logic [AW-1:0]     sel_i,
  output logic              valid_o,
  output logic [AW-1:0]     ep_o,
  output logic [LEN_W-1:0]  len_o
);
  logic [LEN_W-1:0] len_q [NUM_EP];
  logic [LEN_W-1:0] len_next;

  assign len_next = len_q[sel_i] + LEN_W'(acc_push_i[sel_i]);

  for (genvar e = 0; e < NUM_EP; e++) begin : g_len
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            len_q[e] <= '0;
      else if (commit_i && sel_i == AW'(e))  len_q[e] <= '0;
      else if (acc_push_i[e])                 len_q[e] <= len_q[e] + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ep_o    <= '0;
      len_o   <= '0;
    end else begin
      valid_o <= commit_i;
      if (commit_i) begin
        ep_o  <= sel_i;
        len_o <= len_next;
      end
    end
  end
endmodule

// File: rtl/slv_fifo_port.sv
module slv_fifo_port
  import slv_fifo_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int DW     = 16,
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 10,
  localparam int AW    = $clog2(NUM_EP),
  localparam int LANES = DW / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_mode_i,
  input  logic [NUM_EP-1:0] cfg_word_i,
  input  logic              cs_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              oe_i,
  input  logic              pktend_i,
  input  logic [AW-1:0]     fifo_adr_i,
  input  logic [DW-1:0]     data_i,
  output logic [DW-1:0]     data_o,
  output logic [LANES-1:0]  data_oe_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              pkt_valid_o,
  output logic [AW-1:0]     pkt_ep_o,
  output logic [LEN_W-1:0]  pkt_len_o
);
  logic [NUM_STB-1:0] lvl, ev;
  logic [NUM_EP-1:0]  push_v, pop_v, emp_v, ful_v, acc_v;
  logic [DW-1:0]      head_v [NUM_EP];
  logic [DW-1:0]      din_m, head_sel;
  logic               word_sel, drive;

  assign lvl[STB_RD] = ~cs_ni & rd_i;
  assign lvl[STB_WR] = ~cs_ni & wr_i;
  assign lvl[STB_PE] = ~cs_ni & pktend_i;

  for (genvar s = 0; s < NUM_STB; s++) begin : g_stb
    slv_strobe u_stb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sync_mode_i(sync_mode_i),
      .lvl_i      (lvl[s]),
      .ev_o       (ev[s])
    );
  end

  assign word_sel = cfg_word_i[fifo_adr_i];
  assign din_m    = word_sel ? data_i : {{(DW-8){1'b0}}, data_i[7:0]};

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    assign push_v[e] = ev[STB_WR] && (fifo_adr_i == AW'(e));
    assign pop_v[e]  = ev[STB_RD] && (fifo_adr_i == AW'(e));
    slv_ep_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .push_i    (push_v[e]),
      .pop_i     (pop_v[e]),
      .din_i     (din_m),
      .head_o    (head_v[e]),
      .empty_o   (emp_v[e]),
      .full_o    (ful_v[e]),
      .acc_push_o(acc_v[e])
    );
  end

  slv_pkt_cnt #(.NUM_EP(NUM_EP), .LEN_W(LEN_W)) u_pkt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_push_i(acc_v),
    .commit_i  (ev[STB_PE]),
    .sel_i     (fifo_adr_i),
    .valid_o   (pkt_valid_o),
    .ep_o      (pkt_ep_o),
    .len_o     (pkt_len_o)
  );

  assign empty_o  = emp_v[fifo_adr_i];
  assign full_o   = ful_v[fifo_adr_i];
  assign head_sel = head_v[fifo_adr_i];

  // never drive the bus while the outside device writes
  assign drive     = ~cs_ni & oe_i & ~wr_i;
  assign data_oe_o = !drive ? '0 : (word_sel ? {LANES{1'b1}} : LANES'(1));
  assign data_o    = (!drive || empty_o) ? '0 :
                     (word_sel ? head_sel : {{(DW-8){1'b0}}, head_sel[7:0]});
endmodule

// File: rtl/slv_port_chk.sv
module slv_port_chk #(
  parameter int NUM_EP = 4,
  parameter int DW     = 16,
  localparam int AW    = $clog2(NUM_EP),
  localparam int LANES = DW / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_mode_i,
  input logic [NUM_EP-1:0] cfg_word_i,
  input logic              cs_ni,
  input logic              rd_i,
  input logic              wr_i,
  input logic              oe_i,
  input logic [AW-1:0]     fifo_adr_i,
  input logic [DW-1:0]     data_o,
  input logic [LANES-1:0]  data_oe_o,
  input logic              empty_o,
  input logic              full_o,
  input logic              pkt_valid_o
);
  assert_cs_no_drive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> data_oe_o == '0);

  assert_cs_hold_flags_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && cs_ni) |=>
      (!$stable(fifo_adr_i) || ($stable(empty_o) && $stable(full_o))));

  assert_cs_no_commit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && cs_ni) |=> !pkt_valid_o);

  assert_byte_lane_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o != '0 && !cfg_word_i[fifo_adr_i]) |->
      (data_o[DW-1:8] == '0 && data_oe_o == LANES'(1)));

  assert_sync_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && !cs_ni && wr_i && !rd_i && !full_o) |=>
      (!$stable(fifo_adr_i) || !empty_o));

  assert_edge_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_mode_i && !$past(sync_mode_i) && pkt_valid_o) |=> !pkt_valid_o);

  assert_no_drive_on_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> data_oe_o == '0);

  assert_flags_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !empty_o);
endmodule

bind slv_fifo_port slv_port_chk #(.NUM_EP(NUM_EP), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_mode_i(sync_mode_i),
  .cfg_word_i (cfg_word_i),
  .cs_ni      (cs_ni),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .oe_i       (oe_i),
  .fifo_adr_i (fifo_adr_i),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .empty_o    (empty_o),
  .full_o     (full_o),
  .pkt_valid_o(pkt_valid_o)
);

// File: tb/sim_slv_fifo_port.sv
module sim_slv_fifo_port;
  localparam int NEP = 4, DEPTH = 8, LW = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        sync_m = 1'b1;
  logic [3:0]  cfg = 4'b0101;
  logic        cs_n = 1'b1, rd = 1'b0, wr = 1'b0, oe = 1'b0, pe = 1'b0;
  logic [1:0]  adr = 2'd0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  doe;
  logic        emp, ful, pv;
  logic [1:0]  pep;
  logic [LW-1:0] plen;

  slv_fifo_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(sync_m), .cfg_word_i(cfg),
    .cs_ni(cs_n), .rd_i(rd), .wr_i(wr), .oe_i(oe), .pktend_i(pe),
    .fifo_adr_i(adr), .data_i(din), .data_o(dout), .data_oe_o(doe),
    .empty_o(emp), .full_o(ful), .pkt_valid_o(pv), .pkt_ep_o(pep),
    .pkt_len_o(plen)
  );

  int checks = 0, errors = 0, cycles = 0;
  string phase = "reset";
  bit done = 0;

  // behavioural reference
  logic [15:0] mq [NEP][$];
  int  lenc [NEP];
  bit  m_pv;
  int  m_pep, m_plen;
  bit  h1 [3], h2 [3], h3 [3];

  task automatic chk(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] act=%0h exp=%0h t=%0t", req, phase, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit g [3];
    bit ev [3];
    int a, pre;
    g[0] = !cs_n && rd; g[1] = !cs_n && wr; g[2] = !cs_n && pe;
    for (int i = 0; i < 3; i++) begin
      ev[i] = sync_m ? g[i] : (h2[i] && !h3[i]);
      h3[i] = h2[i]; h2[i] = h1[i]; h1[i] = g[i];
    end
    a = int'(adr);
    pre = mq[a].size();
    if (ev[0] && pre > 0) void'(mq[a].pop_front());
    if (ev[1] && pre < DEPTH) begin
      mq[a].push_back(cfg[a] ? din : {8'h00, din[7:0]});
      lenc[a]++;
    end
    m_pv = ev[2];
    if (ev[2]) begin
      m_pep = a;
      m_plen = lenc[a] % (1 << LW);
      lenc[a] = 0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NEP; e++) begin mq[e].delete(); lenc[e] = 0; end
      m_pv = 0; m_pep = 0; m_plen = 0;
      for (int i = 0; i < 3; i++) begin h1[i] = 0; h2[i] = 0; h3[i] = 0; end
    end else begin
      model_step();
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int a, sz;
      bit drv;
      logic [1:0]  e_oe;
      logic [15:0] e_d;
      a = int'(adr);
      sz = mq[a].size();
      drv = !cs_n && oe && !wr;
      e_oe = !drv ? 2'b00 : (cfg[a] ? 2'b11 : 2'b01);
      e_d = (drv && sz > 0) ? (cfg[a] ? mq[a][0] : {8'h00, mq[a][0][7:0]}) : 16'h0;
      chk("R8", emp == (sz == 0), int'(emp), int'(sz == 0));
      chk("R8", ful == (sz == DEPTH), int'(ful), int'(sz == DEPTH));
      chk("R6", doe == e_oe, int'(doe), int'(e_oe));
      chk("R9", dout == e_d, int'(dout), int'(e_d));
      chk("R7", pv == m_pv, int'(pv), int'(m_pv));
      if (m_pv) begin
        chk("R7", int'(pep) == m_pep, int'(pep), m_pep);
        chk("R7", int'(plen) == m_plen, int'(plen), m_plen);
      end
    end
  end

  task automatic drive(bit c_n, bit r, bit w, bit o, bit p, int a, logic [15:0] d);
    @(posedge clk); #2;
    cs_n = c_n; rd = r; wr = w; oe = o; pe = p; adr = 2'(a); din = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b1, 0, 0, 0, 0, int'(adr), din);
  endtask

  task automatic summary();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  always @(posedge clk) cycles++;

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(2);

    phase = "R4 word";
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, 0, 0, 16'hA100 + 16'(i));
    for (int i = 0; i < 4; i++) drive(0, 1, 0, 1, 0, 0, 16'h0);
    drive(0, 0, 1, 0, 0, 0, 16'h1234);
    drive(0, 1, 1, 0, 0, 0, 16'h5678);
    drive(0, 1, 0, 1, 0, 0, 16'h0);
    drive(0, 1, 0, 1, 0, 0, 16'h0);

    phase = "R3 byte";
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, 0, 1, 16'hBEE0 + 16'(i));
    drive(0, 0, 0, 1, 0, 1, 16'h0);
    for (int i = 0; i < 3; i++) drive(0, 1, 0, 1, 0, 1, 16'h0);

    phase = "R2 addr";
    for (int i = 0; i < 8; i++) drive(0, 0, 1, 0, 0, i % 4, 16'hC0DE ^ 16'(i * 16'h1111));
    for (int a = 0; a < 4; a++) drive(0, 0, 0, 1, 0, a, 16'h0);
    for (int i = 0; i < 8; i++) drive(0, 1, 0, 1, 0, 3 - (i % 4), 16'h0);

    phase = "R8 full";
    for (int i = 0; i < DEPTH + 2; i++) drive(0, 0, 1, 0, 0, 2, 16'hF000 + 16'(i));
    drive(0, 1, 1, 0, 0, 2, 16'hDEAD);
    for (int i = 0; i < DEPTH + 2; i++) drive(0, 1, 0, 1, 0, 2, 16'h0);

    phase = "R1 deselect";
    drive(0, 0, 1, 0, 0, 3, 16'h0077);
    for (int i = 0; i < 4; i++) drive(1, i % 2 == 0, i % 2 == 1, 1, 1, 3, 16'h9999);
    drive(0, 0, 0, 1, 0, 3, 16'h0);

    phase = "R6 oe+wr";
    drive(0, 0, 1, 1, 0, 0, 16'h4242);
    drive(0, 0, 0, 1, 0, 0, 16'h0);

    phase = "R7 commit";
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, 0, 1, 16'h00A0 + 16'(i));
    drive(0, 0, 1, 0, 1, 1, 16'h00AF);
    drive(0, 0, 0, 0, 1, 1, 16'h0);
    drive(0, 0, 0, 0, 0, 0, 16'h0);
    drive(0, 0, 0, 0, 1, 0, 16'h0);
    idle(2);

    phase = "R5 edge";
    sync_m = 1'b0;
    idle(4);
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 4; i++) drive(0, 0, 1, 0, 0, 3, 16'h3300 + 16'(p));
      for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, 0, 3, 16'h3300 + 16'(p));
    end
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 1, 3, 16'h0);
    idle(4);
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 5; i++) drive(0, 1, 0, 1, 0, 3, 16'h0);
      for (int i = 0; i < 4; i++) drive(0, 0, 0, 1, 0, 3, 16'h0);
    end
    phase = "R1 edge";
    for (int i = 0; i < 3; i++) drive(1, 0, 1, 0, 1, 3, 16'h5555);
    idle(5);
    drive(0, 0, 0, 1, 0, 3, 16'h0);
    drive(0, 0, 0, 1, 0, 3, 16'h0);

    phase = "drain";
    sync_m = 1'b1;
    idle(4);
    for (int a = 0; a < 4; a++)
      for (int i = 0; i < 3; i++) drive(0, 1, 0, 1, 0, a, 16'h0);
    idle(2);
    @(negedge clk); #1;
    summary();
  end
endmodule